// File: doc/BRIEF.md
# Multi-core interrupt routing controller

This block collects 32 level-sensitive interrupt request lines and fans them out to 16 interrupt outputs. The outputs form a grid of 4 cores with 4 request lines each. Every source has a one-byte route that names a set of cores and, on its own, a set of lines. A source that is pending after masking marks each core it names and each line it names. An output at a core and line is raised when that core has at least one source marking it and that line has at least one source marking it. Because of this, routes combine as a cross product and are not handled source by source.

Software programs the block through a small synchronous register port. The port carries a byte address and a size code. It offers the route bytes, an enable mask with separate set and clear ports, a global pending view, and one pending view per core. Read data is returned on the clock after the request. The outputs are registered, so they follow any change on a pin or in the configuration one clock later.

Top module: `core_irq_router`

## Requirements
- R1: After reset, all route bytes, the enable mask, `irq_out` and `bus_rdata` are zero.
- R2: A 1-byte access (`bus_size` = 0) at address `0x00 + i` (i < 32) writes or reads the route byte of source i, using `bus_wdata[7:0]` and `bus_rdata[7:0]`, with the upper read bits zero. Bits 3:0 of the route byte select cores 0 to 3, and bits 7:4 select lines 0 to 3.
- R3: A 4-byte write (`bus_size` = 2) to `0x28` ORs `bus_wdata` into the enable mask. A 4-byte write to `0x2C` clears every mask bit that is set in `bus_wdata`. A 4-byte read of `0x24` returns the mask.
- R4: A 4-byte read of `0x20` returns the current `irq_in` levels ANDed with the enable mask. It is level-sensitive and holds no memory of earlier pulses.
- R5: A 4-byte read of `0x40 + 8*c` (c < 4) returns the global pending word filtered to the sources whose route byte has core bit c set. A read of `0x44 + 8*c` returns zero. Writes to these slots have no effect on what they read back.
- R6: `irq_out[c*4 + l]` is high if and only if some pending source routes to core c and some pending source (the same one or another) routes to line l. It changes one clock after the pin or configuration change that causes it.
- R7: Accesses that do not match a register read zero and leave all state unchanged. These are: a route byte accessed with a size other than 1 byte, any other register accessed with a size other than 4 bytes or at an address that is not 4-aligned, and any unmapped address. Size code 1 means 2 bytes and code 3 is reserved.
- R8: `bus_rdata` carries the data of a read request issued on the previous clock. It is zero on the clock after any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| irq_out | output | 16 | Routed outputs, index core*4 + line |

## Verification
The hardest situation to reach is an output raised only by the cross product. In that case no single source routes to both the core and the line, but one source supplies the core and a different source supplies the line. A directed task sets up two sources with disjoint core and line sets. It checks that the mixed outputs are raised and that they fall when either source is masked. A random phase then toggles pins and rewrites route bytes and mask bits. After every step it compares all 16 outputs against a model in the bench, so multi-core, multi-line routes and overlapping routes occur many times.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int BUS_AW = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [BUS_AW-1:0] OFS_GSTAT = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_MASK  = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_MSET  = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_MCLR  = 8'h2C;
  localparam logic [BUS_AW-1:0] OFS_CORE0 = 8'h40;
  localparam int               CORE_STRIDE = 8;

  // A byte access inside the route table.
  function automatic logic route_hit(input logic [1:0] sz, input logic [BUS_AW-1:0] a,
                                     input int n_src);
    return (sz == SZ_BYTE) && (int'(a) < n_src);
  endfunction

  // An aligned full-word access.
  function automatic logic word_hit(input logic [1:0] sz, input logic [BUS_AW-1:0] a);
    return (sz == SZ_WORD) && (a[1:0] == 2'b00);
  endfunction

  // The first word of a per-core slot.
  function automatic logic core_slot_hit(input logic [BUS_AW-1:0] a, input int n_core);
    return (int'(a) >= int'(OFS_CORE0)) &&
           (int'(a) < int'(OFS_CORE0) + CORE_STRIDE * n_core) &&
           (a[2] == 1'b0);
  endfunction

endpackage

// File: rtl/irqr_cfg.sv
module irqr_cfg
  import irqr_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int RW    = 8,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_size,
  input  logic [BUS_AW-1:0]         wr_addr,
  input  logic [DW-1:0]             wr_data,
  output logic [N_SRC-1:0][RW-1:0]  route,
  output logic [N_SRC-1:0]          mask
);
  localparam int SIDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic route_wr, mset_wr, mclr_wr;
  logic [SIDX_W-1:0] src_sel;

  assign route_wr = wr_en && route_hit(wr_size, wr_addr, N_SRC);
  assign mset_wr  = wr_en && word_hit(wr_size, wr_addr) && (wr_addr == OFS_MSET);
  assign mclr_wr  = wr_en && word_hit(wr_size, wr_addr) && (wr_addr == OFS_MCLR);
  assign src_sel  = wr_addr[SIDX_W-1:0];

  for (genvar s = 0; s < N_SRC; s++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rst_n)                               route[s] <= '0;
      else if (route_wr && (int'(src_sel) == s)) route[s] <= wr_data[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mset_wr) mask <= mask | wr_data[N_SRC-1:0];
    else if (mclr_wr) mask <= mask & ~wr_data[N_SRC-1:0];
  end
endmodule

// File: rtl/irqr_fanout.sv
module irqr_fanout #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4
) (
  input  logic [N_SRC-1:0]                        pins,
  input  logic [N_SRC-1:0]                        mask,
  input  logic [N_SRC-1:0][N_CORE+N_LINE-1:0]     route,
  output logic [N_SRC-1:0]                        gstat,
  output logic [N_CORE-1:0][N_SRC-1:0]            core_pend,
  output logic [N_CORE*N_LINE-1:0]                out_next
);
  logic [N_LINE-1:0][N_SRC-1:0] line_pend;
  logic [N_CORE-1:0]            core_any;
  logic [N_LINE-1:0]            line_any;

  assign gstat = pins & mask;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar c = 0; c < N_CORE; c++) begin : g_c
      assign core_pend[c][s] = gstat[s] & route[s][c];
    end
    for (genvar l = 0; l < N_LINE; l++) begin : g_l
      assign line_pend[l][s] = gstat[s] & route[s][N_CORE+l];
    end
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_cany
    assign core_any[c] = |core_pend[c];
  end
  for (genvar l = 0; l < N_LINE; l++) begin : g_lany
    assign line_any[l] = |line_pend[l];
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_oc
    for (genvar l = 0; l < N_LINE; l++) begin : g_ol
      assign out_next[c*N_LINE + l] = core_any[c] & line_any[l];
    end
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import irqr_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4,
  parameter int DW     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [1:0]                 bus_size,
  input  logic [BUS_AW-1:0]          bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  input  logic [N_SRC-1:0]           irq_in,
  output logic [N_CORE*N_LINE-1:0]   irq_out
);
  localparam int RW     = N_CORE + N_LINE;
  localparam int N_OUT  = N_CORE * N_LINE;
  localparam int SIDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int CIDX_W = (N_CORE > 1) ? $clog2(N_CORE) : 1;

  logic [N_SRC-1:0][RW-1:0]     route;
  logic [N_SRC-1:0]             mask_q;
  logic [N_SRC-1:0]             gstat;
  logic [N_CORE-1:0][N_SRC-1:0] core_pend;
  logic [N_OUT-1:0]             out_next;
  logic                         wr_fire, rd_fire;
  logic [BUS_AW-1:0]            slot_off;
  logic [CIDX_W-1:0]            core_sel;
  logic [DW-1:0]                rd_mux;

  assign wr_fire  = bus_en & bus_we;
  assign rd_fire  = bus_en & ~bus_we;
  assign slot_off = bus_addr - OFS_CORE0;
  assign core_sel = slot_off[3 +: CIDX_W];

  irqr_cfg #(.N_SRC(N_SRC), .RW(RW), .DW(DW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_size(bus_size),
    .wr_addr(bus_addr), .wr_data(bus_wdata), .route(route), .mask(mask_q)
  );

  irqr_fanout #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)) fan_i (
    .pins(irq_in), .mask(mask_q), .route(route),
    .gstat(gstat), .core_pend(core_pend), .out_next(out_next)
  );

  always_comb begin
    rd_mux = '0;
    if (route_hit(bus_size, bus_addr, N_SRC)) begin
      rd_mux[RW-1:0] = route[bus_addr[SIDX_W-1:0]];
    end else if (word_hit(bus_size, bus_addr)) begin
      if (bus_addr == OFS_GSTAT)                 rd_mux[N_SRC-1:0] = gstat;
      else if (bus_addr == OFS_MASK)             rd_mux[N_SRC-1:0] = mask_q;
      else if (core_slot_hit(bus_addr, N_CORE))  rd_mux[N_SRC-1:0] = core_pend[core_sel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_out   <= '0;
    end else begin
      bus_rdata <= rd_fire ? rd_mux : '0;
      irq_out   <= out_next;
    end
  end
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker #(
  parameter int N_SRC  = 32,
  parameter int N_OUT  = 16,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [7:0]        bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [N_SRC-1:0]  irq_in,
  input logic [N_OUT-1:0]  irq_out,
  input logic [N_SRC-1:0]  mask_q
);
  // R3: write-1-to-set leaves every written bit set
  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_size == 2'd2 && bus_addr == 8'h28)
      |=> ((mask_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

  // R3: write-1-to-clear leaves every written bit clear
  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_size == 2'd2 && bus_addr == 8'h2C)
      |=> ((mask_q & $past(bus_wdata[N_SRC-1:0])) == '0));

  // R6: a raised output needs an enabled, asserted source one clock earlier
  p_out_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ($past(irq_in & mask_q) != '0));

  // R7: two-byte reads return zero
  p_half_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_size == 2'd1) |=> (bus_rdata == '0));

  // R8: no read request, no read data
  p_idle_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en || bus_we) |=> (bus_rdata == '0));
endmodule

bind core_irq_router irqr_checker #(.N_SRC(N_SRC), .N_OUT(N_CORE*N_LINE), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_size(bus_size),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_in(irq_in), .irq_out(irq_out), .mask_q(mask_q)
);

// File: tb/core_irq_router_tb.sv
module core_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [15:0] irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  route_m [32];
  logic [31:0] mask_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // Bench model: core c sees source i if its route has bit c; line l if bit 4+l.
  function automatic logic [15:0] model_out(input logic [31:0] pins);
    logic [15:0] o;
    logic [31:0] pend;
    o = '0;
    pend = pins & mask_m;
    for (int c = 0; c < 4; c++) begin
      for (int l = 0; l < 4; l++) begin
        logic hc, hl;
        hc = 1'b0; hl = 1'b0;
        for (int i = 0; i < 32; i++) begin
          if (pend[i] && route_m[i][c])   hc = 1'b1;
          if (pend[i] && route_m[i][4+l]) hl = 1'b1;
        end
        o[4*c + l] = hc && hl;
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] model_core(input int c);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 32; i++) w[i] = irq_in[i] & mask_m[i] & route_m[i][c];
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] sz, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_size = sz; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic set_route(input int i, input logic [7:0] v);
    bus_wr(2'd0, 8'(i), {24'h0, v});
    route_m[i] = v;
  endtask

  task automatic mask_set(input logic [31:0] v);
    bus_wr(2'd2, 8'h28, v);
    mask_m = mask_m | v;
  endtask

  task automatic mask_clr(input logic [31:0] v);
    bus_wr(2'd2, 8'h2C, v);
    mask_m = mask_m & ~v;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic check_out(input string req);
    @(negedge clk);
    chk(req, "irq_out", {16'h0, irq_out}, {16'h0, model_out(irq_in)});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "rdata after reset", bus_rdata, '0);
    chk("R1", "irq_out after reset", {16'h0, irq_out}, '0);
    bus_rd(2'd2, 8'h24, d);
    chk("R1", "mask after reset", d, '0);
    bus_rd(2'd0, 8'h05, d);
    chk("R1", "route byte 5 after reset", d, '0);
  endtask

  task automatic t_route_rw;
    logic [31:0] d;
    set_route(0, 8'h11);
    set_route(17, 8'hA5);
    set_route(31, 8'hFF);
    bus_rd(2'd0, 8'h00, d); chk("R2", "route 0", d, 32'h11);
    bus_rd(2'd0, 8'h11, d); chk("R2", "route 17", d, 32'hA5);
    bus_rd(2'd0, 8'h1F, d); chk("R2", "route 31", d, 32'hFF);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    mask_set(32'h0000_F00F);
    mask_set(32'h8000_0000);
    bus_rd(2'd2, 8'h24, d); chk("R3", "mask after sets", d, 32'h8000_F00F);
    mask_clr(32'h0000_3001);
    bus_rd(2'd2, 8'h24, d); chk("R3", "mask after clear", d, 32'h8000_C00E);
    mask_clr(32'hFFFF_FFFF);
    bus_rd(2'd2, 8'h24, d); chk("R3", "mask all cleared", d, 32'h0);
  endtask

  task automatic t_gstat;
    logic [31:0] d;
    mask_set(32'h00FF_00FF);
    set_pins(32'h0F0F_0F0F);
    bus_rd(2'd2, 8'h20, d); chk("R4", "global status", d, 32'h000F_000F);
    set_pins(32'h0000_0000);
    bus_rd(2'd2, 8'h20, d); chk("R4", "status follows level low", d, 32'h0);
  endtask

  task automatic t_core_stat;
    logic [31:0] d;
    set_route(2, 8'h15);   // cores 0 and 2, line 0
    set_route(3, 8'h22);   // core 1, line 1
    mask_set(32'h0000_000C);
    set_pins(32'h0000_000C);
    for (int c = 0; c < 4; c++) begin
      bus_rd(2'd2, 8'(8'h40 + 8*c), d); chk("R5", "core status", d, model_core(c));
    end
    bus_rd(2'd2, 8'h44, d); chk("R5", "upper word of slot 0", d, 32'h0);
    bus_wr(2'd2, 8'h40, 32'hFFFF_FFFF);
    bus_rd(2'd2, 8'h40, d); chk("R5", "core 0 after write", d, model_core(0));
    check_out("R6");
  endtask

  task automatic t_cross;
    for (int i = 0; i < 32; i++) set_route(i, 8'h00);
    mask_clr(32'hFFFF_FFFF);
    set_route(3, 8'h63);   // cores 0,1  lines 1,2
    set_route(7, 8'h84);   // core 2     line 3
    mask_set(32'h0000_0088);
    set_pins(32'h0000_0008);
    check_out("R6");
    chk("R6", "single multi route", {16'h0, irq_out}, 32'h0000_0066);
    set_pins(32'h0000_0088);
    check_out("R6");
    chk("R6", "cross product", {16'h0, irq_out}, 32'h0000_0EEE);
    mask_clr(32'h0000_0008);
    check_out("R6");
    chk("R6", "mask removes mixing", {16'h0, irq_out}, 32'h0000_0800);
  endtask

  task automatic t_illegal;
    logic [31:0] d;
    mask_clr(32'hFFFF_FFFF);
    set_route(4, 8'h3C);
    bus_wr(2'd2, 8'h04, 32'hFFFF_FFFF);
    bus_rd(2'd0, 8'h04, d); chk("R7", "word write to route ignored", d, 32'h3C);
    bus_rd(2'd2, 8'h04, d); chk("R7", "word read of route", d, 32'h0);
    bus_wr(2'd0, 8'h28, 32'hFF);
    bus_wr(2'd1, 8'h28, 32'hFFFF);
    bus_wr(2'd2, 8'h29, 32'hFFFF_FFFF);
    bus_rd(2'd2, 8'h24, d); chk("R7", "bad-size mask writes ignored", d, 32'h0);
    mask_set(32'h0000_00F0);
    bus_rd(2'd1, 8'h24, d); chk("R7", "half read", d, 32'h0);
    bus_rd(2'd2, 8'h26, d); chk("R7", "misaligned read", d, 32'h0);
    bus_rd(2'd0, 8'h24, d); chk("R7", "byte read of mask", d, 32'h0);
    bus_rd(2'd3, 8'h24, d); chk("R7", "reserved size read", d, 32'h0);
    bus_rd(2'd2, 8'h30, d); chk("R7", "unmapped read", d, 32'h0);
    bus_rd(2'd2, 8'h60, d); chk("R7", "past last core slot", d, 32'h0);
  endtask

  task automatic t_rdata_timing;
    logic [31:0] d;
    bus_rd(2'd2, 8'h24, d); chk("R8", "read data next clock", d, mask_m);
    @(negedge clk);
    chk("R8", "rdata idle after read", bus_rdata, 32'h0);
  endtask

  task automatic t_random;
    logic [31:0] d;
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 5);
      if (op <= 2)      set_pins(irq_in ^ (32'h1 << $urandom_range(0, 31)));
      else if (op == 3) set_route($urandom_range(0, 31), 8'($urandom));
      else if (op == 4) mask_set(32'h1 << $urandom_range(0, 31));
      else              mask_clr(32'h1 << $urandom_range(0, 31));
      check_out("R6");
      if (k % 16 == 0) begin
        int c;
        c = $urandom_range(0, 3);
        bus_rd(2'd2, 8'h20, d); chk("R4", "random global status", d, irq_in & mask_m);
        bus_rd(2'd2, 8'(8'h40 + 8*c), d); chk("R5", "random core status", d, model_core(c));
      end
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) route_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_route_rw;
    t_mask;
    t_gstat;
    t_core_stat;
    t_cross;
    t_illegal;
    t_rdata_timing;
    t_random;
    done = 1'b1;
    report;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1-run: actual not finished expected finished");
      report;
      $finish;
    end
  end
endmodule